// File: doc/BRIEF.md
# Packed-Pixel Raster Scanout

This block drives a 640x400 display from a framebuffer of 32-bit words. It runs its own horizontal and vertical counters and issues one read to video memory for every eight visible pixels. Each returned word is split into eight 4-bit colour indices, leftmost pixel first. Every index goes through a writable 16-entry palette of 12-bit colours, and the result drives the 4-bit red, green and blue outputs.

Line and frame timing use 800 clocks per line and 449 lines per frame. The sync outputs and a vertical-blank flag are delayed so that they line up with the colour outputs. A simple write port lets the palette be changed at any time, including during visible lines.

Top module: `pixel_scanout`

## Requirements
- R1: While reset is held, and until the first pixel reaches the outputs, red, green and blue are 0, hsync is 1 and vsync and vblank are 0.
- R2: During visible lines the block pulses mem_rd for one clock every eighth pixel, starting at the first pixel of the line. mem_addr counts up by one per read. It restarts at 0 each frame, so line n starts at word n*(H_ACTIVE/8), which is 80*n at the default size. Read data is taken from mem_data on the clock after mem_rd.
- R3: Within a word, bits 31:28 are the leftmost pixel and bits 3:0 the rightmost. The pixels are shown in that order on consecutive clocks.
- R4: A pixel value v shows palette entry v, with red from bits 11:8, green from bits 7:4 and blue from bits 3:0. When pal_we is high at a clock edge, pal_rgb is written to entry pal_idx. Any pixel whose lookup happens after that edge uses the new colour, even in the middle of a line.
- R5: hsync is 0 for 96 clocks that begin 16 clocks after the last visible pixel of a line. Otherwise it is 1.
- R6: vsync is 1 for lines 412 and 413 of each 449-line frame. Otherwise it is 0.
- R7: vblank is 1 on every line from 400 to 448 and 0 on lines 0 to 399.
- R8: red, green and blue are 0 whenever the pixel position is outside the 640x400 visible area.
- R9: Counting clock cycles from reset release, starting at 0, the pixel at column x of line y appears in cycle 800*y + x + 3. hsync, vsync and vblank have the same three-cycle delay, and the frame repeats every 800*449 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 15 | Word address to video memory |
| mem_rd | output | 1 | Read strobe, data expected on the next clock |
| mem_data | input | 32 | Word returned by video memory |
| pal_we | input | 1 | Palette write enable |
| pal_idx | input | 4 | Palette entry to write |
| pal_rgb | input | 12 | Colour to write (red 11:8, green 7:4, blue 3:0) |
| red | output | 4 | Red intensity |
| green | output | 4 | Green intensity |
| blue | output | 4 | Blue intensity |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active high |
| vblank | output | 1 | High during vertical blanking |

## Verification
Video memory is modelled with a hash of the address, so every word differs and any wrong address or nibble order shows up as a wrong colour. The palette is loaded with sixteen distinct colours during the first visible line, and one entry is rewritten in the middle of a later line. This separates the colour from before the write and the colour from after it at the exact pixel where the change takes effect. A reduced raster lets two whole frames run, so the frame wrap, the address restart and every sync and blank edge are compared on every cycle against a position model.

// File: rtl/pixel_scanout.sv
module pixel_scanout #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 400,
  parameter int V_FP     = 12,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 35,
  parameter int ADDR_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [31:0]       mem_data,
  input  logic              pal_we,
  input  logic [3:0]        pal_idx,
  input  logic [11:0]       pal_rgb,
  output logic [3:0]        red,
  output logic [3:0]        green,
  output logic [3:0]        blue,
  output logic              hsync,
  output logic              vsync,
  output logic              vblank
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HW-1:0]     hpos;
  logic [VW-1:0]     vpos;
  logic [ADDR_W-1:0] faddr;
  logic              rd_q;
  logic [31:0]       shreg;
  logic [1:0]        act_q;
  logic [2:0]        hs_q, vs_q, vb_q;
  logic [11:0]       pal [16];
  logic [11:0]       rgb_q;

  wire line_end  = hpos == H_LAST;
  wire frame_end = line_end && vpos == V_LAST;
  wire in_active = hpos < H_VIS && vpos < V_VIS;
  wire hs_now    = !(hpos >= HS_BEG && hpos < HS_END);
  wire vs_now    = vpos >= VS_BEG && vpos < VS_END;
  wire vb_now    = vpos >= V_VIS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_end) begin
      hpos <= '0;
      vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  assign mem_rd   = in_active && hpos[2:0] == 3'd0;
  assign mem_addr = faddr;

  always_ff @(posedge clk) begin
    if (!rst_n)         faddr <= '0;
    else if (frame_end) faddr <= '0;
    else if (mem_rd)    faddr <= faddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      shreg <= '0;
    end else begin
      rd_q  <= mem_rd;
      shreg <= rd_q ? mem_data : {shreg[27:0], 4'h0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      hs_q  <= '1;
      vs_q  <= '0;
      vb_q  <= '0;
    end else begin
      act_q <= {act_q[0], in_active};
      hs_q  <= {hs_q[1:0], hs_now};
      vs_q  <= {vs_q[1:0], vs_now};
      vb_q  <= {vb_q[1:0], vb_now};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pal[i] <= '0;
    end else if (pal_we) begin
      pal[pal_idx] <= pal_rgb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= act_q[1] ? pal[shreg[31:28]] : 12'h000;
  end

  assign red    = rgb_q[11:8];
  assign green  = rgb_q[7:4];
  assign blue   = rgb_q[3:0];
  assign hsync  = hs_q[2];
  assign vsync  = vs_q[2];
  assign vblank = vb_q[2];
endmodule

module scanout_checks #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        red,
  input logic [3:0]        green,
  input logic [3:0]        blue,
  input logic              hsync,
  input logic              vsync,
  input logic              vblank,
  input logic              pal_we,
  input logic [3:0]        pal_idx,
  input logic [11:0]       pal_rgb,
  input logic [11:0]       pal_mem [16]
);
  assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_addr == $past(mem_addr) + 1'b1);

  assert_pal_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |=> pal_mem[$past(pal_idx)] == $past(pal_rgb));

  assert_dark_in_hsync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync |-> {red, green, blue} == 12'h000);

  assert_vsync_in_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> vblank);

  assert_dark_in_vblank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> {red, green, blue} == 12'h000);
endmodule

bind pixel_scanout scanout_checks #(.ADDR_W(ADDR_W)) u_scanout_checks (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync),
  .vblank(vblank), .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
  .pal_mem(pal)
);

// File: tb/test_pixel_scanout.sv
module test_pixel_scanout;
  // reduced raster so whole frames fit the run
  localparam int HA = 64, HF = 4, HS = 8, HB = 4;
  localparam int VA = 6, VF = 2, VS = 1, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int WPL = HA / 8;
  localparam int FRAME = HT * VT;

  localparam logic [15:0] PAL_TAB [16] = '{
    16'h00F9, 16'h11E8, 16'h22DB, 16'h33CA, 16'h44BD, 16'h55AC, 16'h669F, 16'h778E,
    16'h8871, 16'h9960, 16'hAA53, 16'hBB42, 16'hCC35, 16'hDD24, 16'hEE17, 16'hFF06
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, pal_we, mem_rd, hsync, vsync, vblank;
  logic [14:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  pal_idx, red, green, blue;
  logic [11:0] pal_rgb;

  pixel_scanout #(.H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                  .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
                  .ADDR_W(15)) i_pixel_scanout (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .pal_we(pal_we), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync),
    .vblank(vblank));

  function automatic logic [31:0] word_of(input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E3779B1;
    return v ^ 32'hA5C30F1E;
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= word_of(int'(mem_addr));

  int checks = 0, errs = 0;
  bit run = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int ncyc = 0, rd_cnt = 0, addr_line1 = -1, addr_frame2 = -1;
  logic [11:0] pal_m [16];
  logic [11:0] exp_rgb;
  logic        exp_hs, exp_vs, exp_vb;
  string       rgb_tag;

  always @(posedge clk) begin
    if (!run) begin
      for (int i = 0; i < 16; i++) pal_m[i] = 12'h000;
    end else begin
      if (mem_rd && ncyc < FRAME) rd_cnt++;
      if (mem_rd && ncyc == HT) addr_line1 = int'(mem_addr);
      if (mem_rd && ncyc == FRAME) addr_frame2 = int'(mem_addr);
      ncyc++;
      begin
        int pos, p, x, y;
        logic [31:0] w;
        logic [3:0] nib;
        pos = ncyc - 3;   // R9: three cycles from counter to pins
        if (pos < 0) begin
          exp_rgb = 12'h000; exp_hs = 1'b1; exp_vs = 1'b0; exp_vb = 1'b0;
          rgb_tag = "R1";
        end else begin
          p = pos % FRAME; x = p % HT; y = p / HT;
          exp_hs = !(x >= HA + HF && x < HA + HF + HS);
          exp_vs = y >= VA + VF && y < VA + VF + VS;
          exp_vb = y >= VA;
          if (x < HA && y < VA) begin
            w = word_of(y * WPL + x / 8);
            nib = 4'((w >> (28 - 4 * (x % 8))) & 32'hF);
            exp_rgb = pal_m[nib];
            rgb_tag = (x == 0) ? "R9" : (nib == 4'd5) ? "R4" : "R3";
          end else begin
            exp_rgb = 12'h000;
            rgb_tag = "R8";
          end
        end
      end
      if (pal_we) pal_m[pal_idx] = pal_rgb;
    end
  end

  always @(negedge clk) begin
    if (run && ncyc > 0) begin
      chk({red, green, blue} == exp_rgb, rgb_tag, 32'({red, green, blue}), 32'(exp_rgb));
      chk(hsync == exp_hs, "R5", 32'(hsync), 32'(exp_hs));
      chk(vsync == exp_vs, "R6", 32'(vsync), 32'(exp_vs));
      chk(vblank == exp_vb, "R7", 32'(vblank), 32'(exp_vb));
    end
  end

  initial begin
    rst_n = 0; pal_we = 0; pal_idx = '0; pal_rgb = '0;
    repeat (3) @(negedge clk);
    chk({red, green, blue} == 12'h000, "R1 colour in reset", 32'({red, green, blue}), 32'h0);
    chk(hsync == 1'b1, "R1 hsync in reset", 32'(hsync), 32'h1);
    chk(vsync == 1'b0, "R1 vsync in reset", 32'(vsync), 32'h0);
    chk(vblank == 1'b0, "R1 vblank in reset", 32'(vblank), 32'h0);
    rst_n = 1; run = 1;
    for (int i = 0; i < 16; i++) begin
      pal_we = 1; pal_idx = PAL_TAB[i][15:12]; pal_rgb = PAL_TAB[i][11:0];
      @(negedge clk);
    end
    pal_we = 0;
    while (ncyc < FRAME + 2 * HT + 20) @(negedge clk);
    pal_we = 1; pal_idx = 4'd5; pal_rgb = 12'h3C7;   // R4 mid-line rewrite
    @(negedge clk);
    pal_we = 0;
    while (ncyc < 2 * FRAME + 10) @(negedge clk);
    run = 0;
    chk(rd_cnt == WPL * VA, "R2 reads per frame", 32'(rd_cnt), 32'(WPL * VA));
    chk(addr_line1 == WPL, "R2 line 1 start address", 32'(addr_line1), 32'(WPL));
    chk(addr_frame2 == 0, "R2 frame restart address", 32'(addr_frame2), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule